// File: doc/BRIEF.md
# Configuration-space serial EEPROM bridge

This block sits between a host's configuration-space access path and the default configuration register logic of an adapter. It lets software drive a three-wire serial configuration EEPROM by hand. Writes to two reserved offsets are intercepted. One sets the EEPROM select line and loads the clock and data-in lines from two bits of the written value. The other drops all three lines. Every other configuration write is forwarded unchanged. The EEPROM data-out line comes back through the configuration read path: a single-byte read at offset zero has its low byte forced to zero whenever data-out is low.

Configuration writes enter on a valid/ready channel. A write to a reserved offset is taken at once (ready high), whatever the downstream state. Any other write is offered on the forwarding channel in the same cycle, and its ready is the downstream ready, so back-pressure passes straight through. The read path is a combinational gate placed on the default logic's read data.

A checksum accumulator watches the serial data that software clocks out of the EEPROM. After an arm pulse, it collects one data-out bit on each host write that raises the clock line. It assembles these bits into 16-bit words and sums them modulo 2^16. After 64 words it reports whether the total equals 0x1234, which is the value a consistent image gives: its last word equals 0x1234 minus the sum of the other 63.

Top module: `cfg_eeprom_bridge`

## Requirements
- R1: An accepted write at offset 0x80 sets rom_sel to 1, rom_clk to data bit 7 and rom_din to data bit 6, all visible from the next clock cycle.
- R2: An accepted write at offset 0xC0 drives rom_sel, rom_clk and rom_din to 0 from the next cycle.
- R3: After reset all three pins and both status outputs are 0. The pins hold their value in every cycle that has no write to offset 0x80 or 0xC0.
- R4: A write at any offset other than 0x80 or 0xC0 appears on the forwarding channel in the same cycle with the same offset and data. hw_ready equals pw_ready for such writes.
- R5: Writes at 0x80 or 0xC0 are never forwarded (pw_valid stays 0), and hw_ready is 1 for them whatever pw_ready is.
- R6: A read with rd_addr 0 and rd_len 1, while rom_dout is 0, returns rd_dflt with bits 7:0 forced to 0 and bits 31:8 unchanged.
- R7: Every other read returns rd_dflt unchanged: a different offset, a length other than 1, or rom_dout high.
- R8: After a chk_arm pulse, one bit is captured on each accepted 0x80 write that has data bit 7 set while rom_clk is currently 0. The captured bit is the rom_dout value in that same cycle. Words are assembled most significant bit first, 16 bits each. A 0x80 write while rom_clk is already 1 captures nothing.
- R9: When the 64th word completes, img_done becomes 1 and img_ok becomes 1 only if the modulo-2^16 sum of all 64 words equals 0x1234. Both then hold, and later bits are ignored until the next arm.
- R10: chk_arm clears img_done, img_ok, the running sum and the bit and word counts. It takes priority over a capture in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_valid | input | 1 | Host configuration write valid |
| hw_ready | output | 1 | Host configuration write accepted |
| hw_addr | input | 8 | Host write offset |
| hw_data | input | 32 | Host write data |
| pw_valid | output | 1 | Forwarded write valid |
| pw_ready | input | 1 | Default logic ready for forwarded write |
| pw_addr | output | 8 | Forwarded write offset |
| pw_data | output | 32 | Forwarded write data |
| rd_addr | input | 8 | Configuration read offset |
| rd_len | input | 3 | Read length in bytes (1, 2 or 4) |
| rd_dflt | input | 32 | Read data from default configuration logic |
| rd_data | output | 32 | Read data returned to host |
| rom_sel | output | 1 | EEPROM chip select |
| rom_clk | output | 1 | EEPROM serial clock |
| rom_din | output | 1 | EEPROM serial data in |
| rom_dout | input | 1 | EEPROM serial data out |
| chk_arm | input | 1 | Start a new checksum pass |
| img_done | output | 1 | 64 words collected |
| img_ok | output | 1 | Collected image sums to 0x1234 |

## Verification
Some rules are checked by assertions on every cycle: the pin updates after reserved-offset writes, pins holding between such writes, select low implying clock and data-in low, the read gate touching only the low byte, and the accumulator never being active once it reports done. Other behaviours only show up in the bench's scenarios. These are the exact order in which bits are captured, the rule that a second clock-high write captures nothing, the pass/fail verdict on a good image and on a corrupted one, back-pressure on forwarded writes, and bits after completion being ignored.

// File: rtl/eebr_pkg.sv
package eebr_pkg;
  typedef struct packed {
    logic sel;
    logic clk;
    logic din;
  } rom_pins_t;
endpackage

// File: rtl/eebr_wr_decode.sv
module eebr_wr_decode
  import eebr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] OFS_BANG = 'h80,
  parameter logic [ADDR_W-1:0] OFS_DROP = 'hC0,
  parameter int BIT_CLK = 7,
  parameter int BIT_DIN = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_valid,
  output logic              hw_ready,
  input  logic [ADDR_W-1:0] hw_addr,
  input  logic [DATA_W-1:0] hw_data,
  output logic              pw_valid,
  input  logic              pw_ready,
  output logic [ADDR_W-1:0] pw_addr,
  output logic [DATA_W-1:0] pw_data,
  output rom_pins_t         pins,
  output logic              rise_stb
);
  logic hit_bang, hit_drop, hit_any;
  rom_pins_t pins_q;

  assign hit_bang = (hw_addr == OFS_BANG);
  assign hit_drop = (hw_addr == OFS_DROP);
  assign hit_any  = hit_bang | hit_drop;

  // forwarding path, back-pressure passes straight through
  assign pw_valid = hw_valid & ~hit_any;
  assign pw_addr  = hw_addr;
  assign pw_data  = hw_data;
  assign hw_ready = hit_any ? 1'b1 : pw_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pins_q <= '0;
    end else if (hw_valid && hit_bang) begin
      pins_q.sel <= 1'b1;
      pins_q.clk <= hw_data[BIT_CLK];
      pins_q.din <= hw_data[BIT_DIN];
    end else if (hw_valid && hit_drop) begin
      pins_q <= '0;
    end
  end

  assign pins     = pins_q;
  assign rise_stb = hw_valid & hit_bang & hw_data[BIT_CLK] & ~pins_q.clk;

  assert_bang_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_valid && hit_bang) |=> (pins.sel && pins.clk == $past(hw_data[BIT_CLK])
                                && pins.din == $past(hw_data[BIT_DIN])));
  assert_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_valid && hit_drop) |=> (pins == '0));
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(hw_valid && hit_any) |=> $stable(pins));
  assert_idle_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !pins.sel |-> (!pins.clk && !pins.din));
  assert_no_fwd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pw_valid |-> (pw_addr != OFS_BANG && pw_addr != OFS_DROP));
endmodule

// File: rtl/eebr_rd_gate.sv
module eebr_rd_gate #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 3
) (
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [LEN_W-1:0]  rd_len,
  input  logic [DATA_W-1:0] rd_dflt,
  input  logic              rom_dout,
  output logic [DATA_W-1:0] rd_data
);
  localparam int NBYTES = DATA_W / 8;
  logic squash;

  assign squash = (rd_addr == '0) && (rd_len == LEN_W'(1)) && !rom_dout;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    if (b == 0) begin : g_low
      assign rd_data[7:0] = squash ? 8'h00 : rd_dflt[7:0];
    end else begin : g_pass
      assign rd_data[b*8 +: 8] = rd_dflt[b*8 +: 8];
    end
  end

  always_comb begin
    assert_low_byte_only_R6: assert (rd_data[DATA_W-1:8] == rd_dflt[DATA_W-1:8]);
  end
endmodule

// File: rtl/eebr_sum_check.sv
module eebr_sum_check #(
  parameter int WORD_W = 16,
  parameter int WORDS  = 64,
  parameter logic [WORD_W-1:0] TARGET = 'h1234
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic bit_stb,
  input  logic bit_val,
  output logic done,
  output logic ok
);
  localparam int BCNT_W = $clog2(WORD_W);
  localparam int WCNT_W = $clog2(WORDS + 1);

  logic              active;
  logic [BCNT_W-1:0] bcnt;
  logic [WCNT_W-1:0] wcnt;
  logic [WORD_W-1:0] shreg, sum, word_nx;

  assign word_nx = {shreg[WORD_W-2:0], bit_val};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0; bcnt <= '0; wcnt <= '0;
      shreg <= '0; sum <= '0; done <= 1'b0; ok <= 1'b0;
    end else if (arm) begin
      active <= 1'b1; bcnt <= '0; wcnt <= '0;
      shreg <= '0; sum <= '0; done <= 1'b0; ok <= 1'b0;
    end else if (active && bit_stb) begin
      shreg <= word_nx;
      if (bcnt == BCNT_W'(WORD_W - 1)) begin
        bcnt <= '0;
        sum  <= sum + word_nx;
        wcnt <= wcnt + 1'b1;
        if (wcnt == WCNT_W'(WORDS - 1)) begin
          active <= 1'b0;
          done   <= 1'b1;
          ok     <= ((sum + word_nx) == TARGET);
        end
      end else begin
        bcnt <= bcnt + 1'b1;
      end
    end
  end

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !active);
  assert_ok_needs_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ok |-> done);
  assert_arm_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (!done && !ok && wcnt == '0));
  assert_word_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wcnt <= WCNT_W'(WORDS));
endmodule

// File: rtl/cfg_eeprom_bridge.sv
module cfg_eeprom_bridge
  import eebr_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int LEN_W  = 3,
  parameter int WORD_W = 16,
  parameter int WORDS  = 64,
  parameter logic [WORD_W-1:0] TARGET = 'h1234,
  parameter logic [ADDR_W-1:0] OFS_BANG = 'h80,
  parameter logic [ADDR_W-1:0] OFS_DROP = 'hC0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_valid,
  output logic              hw_ready,
  input  logic [ADDR_W-1:0] hw_addr,
  input  logic [DATA_W-1:0] hw_data,
  output logic              pw_valid,
  input  logic              pw_ready,
  output logic [ADDR_W-1:0] pw_addr,
  output logic [DATA_W-1:0] pw_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [LEN_W-1:0]  rd_len,
  input  logic [DATA_W-1:0] rd_dflt,
  output logic [DATA_W-1:0] rd_data,
  output logic              rom_sel,
  output logic              rom_clk,
  output logic              rom_din,
  input  logic              rom_dout,
  input  logic              chk_arm,
  output logic              img_done,
  output logic              img_ok
);
  rom_pins_t pins;
  logic      rise_stb;

  eebr_wr_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .OFS_BANG(OFS_BANG), .OFS_DROP(OFS_DROP),
    .BIT_CLK(7), .BIT_DIN(6)
  ) u_wr (
    .clk(clk), .rst_n(rst_n),
    .hw_valid(hw_valid), .hw_ready(hw_ready), .hw_addr(hw_addr), .hw_data(hw_data),
    .pw_valid(pw_valid), .pw_ready(pw_ready), .pw_addr(pw_addr), .pw_data(pw_data),
    .pins(pins), .rise_stb(rise_stb)
  );

  eebr_rd_gate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_rd (
    .rd_addr(rd_addr), .rd_len(rd_len), .rd_dflt(rd_dflt),
    .rom_dout(rom_dout), .rd_data(rd_data)
  );

  eebr_sum_check #(.WORD_W(WORD_W), .WORDS(WORDS), .TARGET(TARGET)) u_sum (
    .clk(clk), .rst_n(rst_n), .arm(chk_arm),
    .bit_stb(rise_stb), .bit_val(rom_dout),
    .done(img_done), .ok(img_ok)
  );

  assign rom_sel = pins.sel;
  assign rom_clk = pins.clk;
  assign rom_din = pins.din;
endmodule

// File: tb/sim_cfg_eeprom_bridge.sv
`timescale 1ns/1ps
module sim_cfg_eeprom_bridge;
  logic clk = 0, rst_n = 0;
  logic hw_valid = 0, pw_ready = 0, rom_dout = 0, chk_arm = 0;
  logic [7:0] hw_addr = 0, rd_addr = 0;
  logic [31:0] hw_data = 0, rd_dflt = 0;
  logic [2:0] rd_len = 4;
  logic hw_ready, pw_valid, rom_sel, rom_clk, rom_din, img_done, img_ok;
  logic [7:0] pw_addr;
  logic [31:0] pw_data, rd_data;

  always #2 clk = ~clk;

  cfg_eeprom_bridge u0 (.*);

  int vectors = 0, miscomp = 0;
  bit m_sel, m_clk, m_din, m_act, m_done, m_ok;
  int m_words;
  logic [15:0] m_sum;
  bit bitq[$];
  logic [15:0] img[64];

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscomp++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic tick(string req);
    bit spec;
    logic [31:0] erd;
    logic [15:0] w;
    #1;
    spec = (hw_addr == 8'h80) || (hw_addr == 8'hC0);
    chk(spec ? "R5" : "R4", "pw_valid", pw_valid, hw_valid && !spec);
    chk(spec ? "R5" : "R4", "hw_ready", hw_ready, spec ? 1'b1 : pw_ready);
    if (hw_valid && !spec) begin
      chk("R4", "pw_addr", pw_addr, hw_addr);
      chk("R4", "pw_data", pw_data, hw_data);
    end
    erd = rd_dflt;
    if (rd_addr == 0 && rd_len == 1 && !rom_dout) erd[7:0] = 8'h00;
    chk((rd_addr == 0 && rd_len == 1 && !rom_dout) ? "R6" : "R7", "rd_data", rd_data, erd);
    @(posedge clk);
    if (!rst_n) begin
      m_sel = 0; m_clk = 0; m_din = 0; m_act = 0; m_done = 0; m_ok = 0;
    end else begin
      if (chk_arm) begin
        m_act = 1; m_done = 0; m_ok = 0; m_sum = 0; m_words = 0; bitq.delete();
      end else if (m_act && hw_valid && hw_addr == 8'h80 && hw_data[7] && !m_clk) begin
        bitq.push_back(rom_dout);
        if (bitq.size() == 16) begin
          w = 0;
          for (int i = 0; i < 16; i++) w = {w[14:0], bitq.pop_front()};
          m_sum = m_sum + w;
          m_words++;
          if (m_words == 64) begin
            m_act = 0; m_done = 1; m_ok = (m_sum == 16'h1234);
          end
        end
      end
      if (hw_valid && hw_addr == 8'h80) begin
        m_sel = 1; m_clk = hw_data[7]; m_din = hw_data[6];
      end else if (hw_valid && hw_addr == 8'hC0) begin
        m_sel = 0; m_clk = 0; m_din = 0;
      end
    end
    @(negedge clk);
    chk(req, "rom_sel", rom_sel, m_sel);
    chk(req, "rom_clk", rom_clk, m_clk);
    chk(req, "rom_din", rom_din, m_din);
    chk("R9", "img_done", img_done, m_done);
    chk("R9", "img_ok", img_ok, m_ok);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, string req);
    hw_valid = 1; hw_addr = a; hw_data = d;
    tick(req);
    hw_valid = 0;
  endtask

  task automatic stream(bit dup);
    chk_arm = 1; tick("R10"); chk_arm = 0;
    for (int w = 0; w < 64; w++)
      for (int b = 15; b >= 0; b--) begin
        rom_dout = 0;
        wr(8'h80, 32'h0000_0040, "R8");
        rom_dout = img[w][b];
        wr(8'h80, 32'h0000_0080, "R8");
        if (dup && w == 0 && b == 15) begin
          rom_dout = ~img[w][b];
          wr(8'h80, 32'h0000_00C0, "R8");
        end
      end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscomp++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
    $finish;
  end

  initial begin
    logic [15:0] s, lf;
    @(negedge clk); tick("R3"); tick("R3");
    rst_n = 1;
    tick("R3");
    // pin control
    wr(8'h80, 32'h0000_0080, "R1");
    wr(8'h80, 32'h0000_0040, "R1");
    wr(8'h80, 32'hFFFF_FFC0, "R1");
    tick("R3"); tick("R3");
    wr(8'hC0, 32'hFFFF_FFFF, "R2");
    tick("R3");
    wr(8'h80, 32'h0000_0000, "R1");
    wr(8'hC0, 32'h0, "R2");
    // forwarding and back-pressure
    pw_ready = 0; wr(8'h04, 32'hDEAD_BEEF, "R4");
    pw_ready = 1; wr(8'h3C, 32'h1234_5678, "R4");
    pw_ready = 0; wr(8'h80, 32'h0000_00C0, "R5");
    wr(8'hC0, 32'h0000_0000, "R5");
    pw_ready = 1; wr(8'h81, 32'hCAFE_0080, "R4");
    // read gate
    rd_dflt = 32'hA5B6_C7D8;
    rd_addr = 0; rd_len = 1; rom_dout = 0; tick("R6");
    rom_dout = 1; tick("R7");
    rom_dout = 0; rd_len = 2; tick("R7");
    rd_len = 4; tick("R7");
    rd_addr = 8'h01; rd_len = 1; tick("R7");
    rd_addr = 0; rd_dflt = 32'h0000_00FF; tick("R6");
    rd_len = 4;
    // good image
    s = 0; lf = 16'hACE1;
    for (int i = 0; i < 63; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      img[i] = lf; s = s + lf;
    end
    img[63] = 16'h1234 - s;
    stream(1);
    chk("R9", "img_ok good", img_ok, 1'b1);
    rom_dout = 0; wr(8'h80, 32'h0, "R9");
    rom_dout = 1; wr(8'h80, 32'h80, "R9");
    // corrupted image
    img[17] = img[17] ^ 16'h0100;
    stream(0);
    chk("R9", "img_ok bad", img_ok, 1'b0);
    chk("R9", "img_done bad", img_done, 1'b1);
    chk_arm = 1; tick("R10"); chk_arm = 0;
    tick("R10");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
    $finish;
  end
endmodule